// File: doc/BRIEF.md
# Warp Issue Scheduler

This block picks, from a pool of hardware thread-group contexts (warps), the warp that owns the issue slot. A warp has 32 threads that all run the same instruction. Eight lanes carry each issue, so one warp issue takes four back-to-back cycles, with eight threads per cycle. The scheduler reports the chosen warp, which group of eight threads is on the lanes this cycle, and whether the slot is in use at all.

Two switching policies are available. In interleaved mode, every new issue goes round-robin to the next ready warp after the one that issued last. A warp that is not ready, or that just reported a stall, is passed over, so the other warps fill the slot. In coarse mode, the scheduler keeps the same warp until that warp reports a long stall. A short stall does not cause a switch; it only leaves the slot empty. The stall inputs describe the warp that issued most recently. Like the mode input, they are sampled only at a sequence boundary.

A sequence boundary is any cycle in which the block is idle, or in which the last group of a warp is on the lanes. Outputs are registered, so a decision made at a boundary shows on the outputs in the following cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: During and right after reset, issueValid is 0 and laneGroup is 0. The first round-robin search after reset begins at warp 0.
- R2: Once a warp issues, it stays on issueWarp for four cycles with issueValid high. Over those cycles laneGroup reads 0, 1, 2 and 3 in that order.
- R3: A different warp can appear on issueWarp only in the cycle after a boundary. A boundary is a cycle that is idle or has laneGroup equal to 3.
- R4: In interleaved mode (modeCoarse=0), the next warp is the first eligible index after the warp that issued last, searching upward and wrapping from 23 to 0. If that warp is the only eligible one, it is chosen again.
- R5: A warp whose bit in warpReady is 0 is never issued. In interleaved mode, shortStall or longStall at a boundary also removes the last-issued warp from that search.
- R6: In coarse mode, the last-issued warp starts a new sequence at every boundary where it is ready and neither stall input is high.
- R7: In coarse mode, shortStall without longStall at a boundary gives one idle cycle and no switch. The same holds when the held warp is not ready.
- R8: In coarse mode, longStall at a boundary switches to the first ready warp after the held one, never the held one itself. If no other warp is ready, the block goes idle.
- R9: While no warp is issuing, issueValid is 0 and laneGroup is 0. A boundary with no eligible warp leaves the block idle.
- R10: modeCoarse is read only at boundaries. A change in the middle of a sequence first affects the next warp choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| warpReady | input | 24 | One bit per warp context, 1 = ready to issue |
| modeCoarse | input | 1 | 0 = interleave every issue, 1 = switch only on long stall |
| shortStall | input | 1 | Last-issued warp hit a short stall (sampled at boundaries) |
| longStall | input | 1 | Last-issued warp hit a long stall (sampled at boundaries) |
| issueValid | output | 1 | Issue slot is occupied this cycle |
| issueWarp | output | 5 | Warp context on the lanes |
| laneGroup | output | 2 | Which eight-thread group is on the lanes (0 to 3) |

## Verification
The hardest cases to reach are those where a stall input or a mode change arrives exactly at the fourth cycle of a sequence. Those are the only samples that count, so a pulse one cycle early or late tests nothing. The hardest of these is a coarse-mode long stall when the held warp is the only ready one.

The stimulus has directed phases that hold stalls and mode steady across whole sequences. A mode toggle is placed in the middle of a sequence. After that comes a long random run in which stalls are raised often, ready masks are sparse, and the mode flips. A behavioural reference model advances cycle by cycle with the same input values, and every output is compared with it on each clock.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  typedef struct packed {
    logic stepLane;
    logic restartCur;
    logic loadPick;
    logic idleLane;
  } seq_strobe_t;
endpackage

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int N = 24,
  parameter int W = 5
) (
  input  logic [N-1:0] reqMask,
  input  logic [W-1:0] lastIdx,
  output logic         found,
  output logic [W-1:0] pickIdx
);
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = int'(lastIdx) + k;
      if (c >= N) c = c - N;
      if (!found && reqMask[c]) begin
        found   = 1'b1;
        pickIdx = W'(c);
      end
    end
  end
endmodule

// File: rtl/warp_sched_dp.sv
module warp_sched_dp
  import warp_sched_pkg::*;
#(
  parameter int N  = 24,
  parameter int W  = 5,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  seq_strobe_t   strb,
  input  logic [N-1:0]  warpReady,
  input  logic          excludeCur,
  output logic [W-1:0]  curWarp,
  output logic [LW-1:0] laneGroup,
  output logic          pickFound,
  output logic          curReady
);
  logic [N-1:0] curOneHot;
  logic [N-1:0] reqMask;
  logic [W-1:0] pickIdx;

  assign curOneHot = {{(N-1){1'b0}}, 1'b1} << curWarp;
  assign reqMask   = warpReady & ~(excludeCur ? curOneHot : '0);
  assign curReady  = warpReady[curWarp];

  warp_rr_pick #(.N(N), .W(W)) uPick (
    .reqMask (reqMask),
    .lastIdx (curWarp),
    .found   (pickFound),
    .pickIdx (pickIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWarp   <= W'(N - 1);
      laneGroup <= '0;
    end else begin
      if (strb.loadPick) curWarp <= pickIdx;
      if (strb.stepLane) laneGroup <= laneGroup + LW'(1);
      else if (strb.restartCur || strb.loadPick || strb.idleLane) laneGroup <= '0;
    end
  end

  a_r5_pick_legal: assert property (@(posedge clk) disable iff (!rstN)
    pickFound |-> (warpReady[pickIdx] && !(excludeCur && pickIdx == curWarp)));
endmodule

// File: rtl/warp_sched_ctrl.sv
module warp_sched_ctrl
  import warp_sched_pkg::*;
#(
  parameter int LANE_CYC = 4,
  parameter int LW       = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modeCoarse,
  input  logic          shortStall,
  input  logic          longStall,
  input  logic          pickFound,
  input  logic          curReady,
  input  logic [LW-1:0] laneGroup,
  output seq_strobe_t   strb,
  output logic          excludeCur,
  output logic          busy
);
  logic haveCur;
  logic nextBusy, nextHave;
  logic isLast, boundary;

  assign isLast   = laneGroup == LW'(LANE_CYC - 1);
  assign boundary = !busy || isLast;
  assign excludeCur = haveCur && (modeCoarse ? longStall : (longStall || shortStall));

  always_comb begin
    strb     = '0;
    nextBusy = busy;
    nextHave = haveCur;
    if (!boundary) begin
      strb.stepLane = 1'b1;
    end else if (modeCoarse && haveCur && !longStall) begin
      if (curReady && !shortStall) begin
        strb.restartCur = 1'b1;
        nextBusy        = 1'b1;
      end else begin
        strb.idleLane = 1'b1;
        nextBusy      = 1'b0;
      end
    end else if (pickFound) begin
      strb.loadPick = 1'b1;
      nextBusy      = 1'b1;
      nextHave      = 1'b1;
    end else begin
      strb.idleLane = 1'b1;
      nextBusy      = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      haveCur <= 1'b0;
    end else begin
      busy    <= nextBusy;
      haveCur <= nextHave;
    end
  end

  a_r9_idle_lane_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> laneGroup == '0);
  a_r2_lane_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !isLast) |=> (busy && laneGroup == $past(laneGroup) + LW'(1)));
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int WARP_SIZE = 32,
  parameter int LANES     = 8,
  localparam int LANE_CYC = WARP_SIZE / LANES,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int LANE_W   = (LANE_CYC > 1) ? $clog2(LANE_CYC) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] warpReady,
  input  logic                 modeCoarse,
  input  logic                 shortStall,
  input  logic                 longStall,
  output logic                 issueValid,
  output logic [WID_W-1:0]     issueWarp,
  output logic [LANE_W-1:0]    laneGroup
);
  seq_strobe_t strb;
  logic excludeCur, pickFound, curReady;
  logic endOfSeq;

  warp_sched_ctrl #(.LANE_CYC(LANE_CYC), .LW(LANE_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeCoarse (modeCoarse),
    .shortStall (shortStall),
    .longStall  (longStall),
    .pickFound  (pickFound),
    .curReady   (curReady),
    .laneGroup  (laneGroup),
    .strb       (strb),
    .excludeCur (excludeCur),
    .busy       (issueValid)
  );

  warp_sched_dp #(.N(NUM_WARPS), .W(WID_W), .LW(LANE_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .warpReady  (warpReady),
    .excludeCur (excludeCur),
    .curWarp    (issueWarp),
    .laneGroup  (laneGroup),
    .pickFound  (pickFound),
    .curReady   (curReady)
  );

  assign endOfSeq = issueValid && laneGroup == LANE_W'(LANE_CYC - 1);

  a_r3_warp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !endOfSeq) |=> $stable(issueWarp));
  a_r6_coarse_keep: assert property (@(posedge clk) disable iff (!rstN)
    (endOfSeq && modeCoarse && !longStall && !shortStall && warpReady[issueWarp])
    |=> (issueValid && issueWarp == $past(issueWarp) && laneGroup == '0));
  a_r8_long_switch: assert property (@(posedge clk) disable iff (!rstN)
    (endOfSeq && modeCoarse && longStall) |=> (!issueValid || issueWarp != $past(issueWarp)));
  a_r9_none_ready: assert property (@(posedge clk) disable iff (!rstN)
    ((!issueValid || endOfSeq) && warpReady == '0) |=> !issueValid);
endmodule

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
  localparam int NW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NW-1:0] warpReady = '0;
  logic modeCoarse = 1'b0, shortStall = 1'b0, longStall = 1'b0;
  logic issueValid;
  logic [4:0] issueWarp;
  logic [1:0] laneGroup;

  int total = 0, bad = 0;
  bit finished = 0;
  int mBusy = 0, mLane = 0, mWarp = NW - 1, mHave = 0;

  always #2 clk = ~clk;

  warp_issue_sched dut (
    .clk(clk), .rstN(rstN), .warpReady(warpReady), .modeCoarse(modeCoarse),
    .shortStall(shortStall), .longStall(longStall),
    .issueValid(issueValid), .issueWarp(issueWarp), .laneGroup(laneGroup)
  );

  task automatic check(string tag);
    int expWarp;
    expWarp = mBusy ? mWarp : int'(issueWarp);
    total++;
    if (int'(issueValid) != mBusy || int'(laneGroup) != mLane || int'(issueWarp) != expWarp) begin
      bad++;
      $display("FAIL %s: valid=%0d/%0d warp=%0d/%0d lane=%0d/%0d (act/exp)",
               tag, issueValid, mBusy, issueWarp, expWarp, laneGroup, mLane);
    end
  endtask

  // reference model: what the outputs become after the next edge
  task automatic driveStep(logic [NW-1:0] rdy, logic mode, logic ss, logic ls);
    bit excl, got;
    int w;
    warpReady = rdy; modeCoarse = mode; shortStall = ss; longStall = ls;
    if (mBusy == 1 && mLane < 3) begin
      mLane++;
    end else if (mode && mHave == 1 && !ls) begin
      mLane = 0;
      mBusy = (rdy[mWarp] && !ss) ? 1 : 0;
    end else begin
      excl = (mHave == 1) && (ls || (!mode && ss));
      got = 0;
      mLane = 0;
      for (int k = 1; k <= NW; k++) begin
        w = (mWarp + k) % NW;
        if (!got && rdy[w] && !(excl && w == mWarp)) begin
          got = 1; mWarp = w;
        end
      end
      mBusy = got ? 1 : 0;
      if (got) mHave = 1;
    end
  endtask

  task automatic cyc(string tag, logic [NW-1:0] rdy, logic mode, logic ss, logic ls);
    @(negedge clk);
    check(tag);
    driveStep(rdy, mode, ss, ls);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rstN = 1'b1;
    driveStep('0, 1'b0, 1'b0, 1'b0);
    cyc("R1 first search from warp 0", '1, 0, 0, 0);
    for (int i = 0; i < 30; i++) cyc("R4 R2 fine round robin all ready", '1, 0, 0, 0);
    for (int i = 0; i < 40; i++) cyc("R4 R5 fine sparse with wrap", 24'h800408, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc("R5 fine short stall skips last", 24'h000060, 0, 1, 0);
    for (int i = 0; i < 12; i++) cyc("R5 fine stall on sole ready warp", 24'h000080, 0, 1, 0);
    for (int i = 0; i < 12; i++) cyc("R9 no warp ready", '0, 0, 0, 0);
    for (int i = 0; i < 6; i++)  cyc("R4 fine restart", 24'h00F000, 0, 0, 0);
    for (int i = 0; i < 20; i++) cyc("R10 R6 mode flips mid sequence", 24'h00F000, 1, 0, 0);
    for (int i = 0; i < 9; i++)  cyc("R7 coarse short stall bubble", 24'h00F000, 1, 1, 0);
    for (int i = 0; i < 12; i++) cyc("R8 coarse long stall switch", 24'h00F000, 1, 0, 1);
    for (int i = 0; i < 8; i++)  cyc("R7 coarse held warp not ready", 24'h000001, 1, 0, 0);
    for (int i = 0; i < 12; i++) cyc("R8 coarse long stall sole warp", 24'h000001, 1, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [NW-1:0] r;
      r = NW'($urandom) & (($urandom % 2) ? NW'($urandom) : '1);
      cyc("R2 R3 R4 R5 R6 R7 R8 R9 R10 random", r, ($urandom % 8) < 4,
          ($urandom % 5) == 0, ($urandom % 6) == 0);
    end
    @(negedge clk);
    check("R2 final");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule